// File: doc/BRIEF.md
# Triggered Command Queue Scan Controller

This block holds a short queue of 32-bit conversion command messages and decides when they may go to a converter back end. A host processor or a DMA engine pushes messages into the queue. A fill request stays high while the queue has a free slot. Each message carries a header half and a command half. Only the command half is passed on. One header bit marks the end of a queue scan.

Commands leave only after software has armed the block and then a software or hardware trigger has arrived. In single-scan mode, the command marked as end of queue stops the transfer, and the block ignores further triggers until it is armed again. In continuous-scan mode, the block returns to the armed state by itself after the end-of-queue command, so the next trigger starts another pass. Three status flags record dropped pushes, starvation during a transfer, and completed scans. These flags stay set until software clears them.

Top module: `cmd_queue_scan`

## Requirements
- R1: After reset, `state_o` is 0 (idle), `cmd_valid` is low, `fill_req` and `push_ready` are high, and all three flags are low. The state code values are: idle 0, armed 1, transferring 2, waiting for rearm 3.
- R2: A message has its header in bits 31:16 and its converter command in bits 15:0. `cmd_out` presents bits 15:0 of accepted messages in the order they were pushed.
- R3: `fill_req` and `push_ready` are high exactly when fewer than DEPTH (default 4) messages are held. A push while the queue is full is dropped, and `ovf_flag` is set in the next cycle.
- R4: `cmd_valid` is high only in the transferring state with a non-empty queue. A pulse on `sw_trig` or `hw_trig` moves the block from armed to transferring.
- R5: In single-scan mode (`mode_o` 0), taking a command whose message bit 31 is set moves the block to the waiting-for-rearm state and sets `eoq_flag`.
- R6: In the waiting-for-rearm state, triggers have no effect: `cmd_valid` stays low and queued messages stay held. A pulse on `arm` returns the block to armed.
- R7: In continuous-scan mode (`mode_o` 1), taking a command whose bit 31 is set returns the block to armed, and the next trigger resumes transfer without `arm`.
- R8: `mode_o` takes the value of `mode_in` only while the block is idle. `arm` moves the block from idle to armed. `disarm` moves the block to idle from any state and takes priority over everything else.
- R9: `udf_flag` is set in the cycle after any cycle in which the block is transferring and the queue is empty.
- R10: The flags are sticky. A `clr_flags` pulse clears them, except that a set condition in the same cycle wins.
- R11: While `cmd_valid` is high and `cmd_ready` is low, both `cmd_valid` and `cmd_out` stay unchanged in the next cycle, unless `disarm` is pulsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| push_valid | input | 1 | Host or DMA offers a message |
| push_data | input | 32 | Message: header 31:16, command 15:0 |
| push_ready | output | 1 | Queue can take a message |
| fill_req | output | 1 | Request to refill the queue |
| cmd_valid | output | 1 | Command is offered to the back end |
| cmd_out | output | 16 | Converter command part |
| cmd_ready | input | 1 | Back end takes the command |
| mode_in | input | 1 | Requested scan mode, 1 for continuous |
| arm | input | 1 | Software arm or rearm pulse |
| disarm | input | 1 | Return to idle |
| sw_trig | input | 1 | Software trigger pulse |
| hw_trig | input | 1 | Hardware trigger pulse |
| clr_flags | input | 1 | Clear the sticky flags |
| state_o | output | 2 | Current state code |
| mode_o | output | 1 | Scan mode in effect |
| ovf_flag | output | 1 | A push was dropped |
| udf_flag | output | 1 | Queue ran empty during a transfer |
| eoq_flag | output | 1 | An end-of-queue command was taken |

## Verification
The assertions assume that `arm`, `disarm`, `clr_flags` and the triggers are single-cycle pulses. They also assume that `cmd_ready` and `push_data` change only between clock edges, and that the back end never depends on `cmd_out` while `cmd_valid` is low. The stimulus meets these assumptions because every input changes one time unit after a rising edge, and every control pulse lasts exactly one cycle. The scoreboard predicts which pushes are accepted from its own count of held messages and never reads the design's occupancy.

// File: rtl/cqs_pkg.sv
// Shared constants and types for the command queue scan controller.
// Assumes a 32-bit message whose upper half is the header.
package cqs_pkg;
    localparam int MSG_W   = 32;
    localparam int CMD_W   = 16;
    localparam int EOQ_POS = 31;
    localparam int NFLAGS  = 3;
    localparam int FL_OVF  = 0;
    localparam int FL_UDF  = 1;
    localparam int FL_EOQ  = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_XFER  = 2'd2,
        ST_WAIT  = 2'd3
    } scan_state_e;
endpackage

// File: rtl/cqs_fifo.sv
// Small synchronous FIFO for command messages.
// Assumes the caller never asserts wr_en when full or rd_en when empty.
// rd_data shows the head entry combinationally.
module cqs_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         full,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;

    // Store a message at the write pointer.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_ptr] <= wr_data;
    end

    // Advance the pointers and track the occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (wr_en) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (rd_en) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            case ({wr_en, rd_en})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // Head and status outputs.
    always_comb begin
        rd_data = mem[rd_ptr];
        full    = (count == CW'(DEPTH));
        empty   = (count == '0);
    end
endmodule

// File: rtl/cqs_seq.sv
// Scan state machine: arm, trigger, end-of-queue handling, and rearm.
// Assumes pop_fire only when the block is transferring, with pop_eoq
// describing the command being taken.
module cqs_seq
    import cqs_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        arm,
    input  logic        disarm,
    input  logic        trig,
    input  logic        mode_in,
    input  logic        pop_fire,
    input  logic        pop_eoq,
    output scan_state_e state,
    output logic        mode_q,
    output logic        xfer_en
);
    scan_state_e nxt;

    // Next-state decision; disarm overrides every other input.
    always_comb begin
        nxt = state;
        if (disarm) begin
            nxt = ST_IDLE;
        end else begin
            case (state)
                ST_IDLE:  if (arm)  nxt = ST_ARMED;
                ST_ARMED: if (trig) nxt = ST_XFER;
                ST_XFER:  if (pop_fire && pop_eoq)
                              nxt = mode_q ? ST_ARMED : ST_WAIT;
                ST_WAIT:  if (arm)  nxt = ST_ARMED;
                default:  nxt = ST_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // The scan mode follows mode_in only while idle.
    always_ff @(posedge clk) begin
        if (!rst_n)                mode_q <= 1'b0;
        else if (state == ST_IDLE) mode_q <= mode_in;
    end

    // Transfer window indicator.
    always_comb xfer_en = (state == ST_XFER);
endmodule

// File: rtl/cqs_flags.sv
// Bank of sticky status flags, one per set input.
// A set condition in the same cycle as the common clear keeps the flag set.
module cqs_flags #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic         clr,
    output logic [N-1:0] flag
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        // One sticky bit.
        always_ff @(posedge clk) begin
            if (!rst_n)      flag[i] <= 1'b0;
            else if (set[i]) flag[i] <= 1'b1;
            else if (clr)    flag[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/cmd_queue_scan.sv
// Top level of the triggered command queue scan controller.
// It joins the message FIFO, the scan state machine, and the status flags.
// It assumes the control inputs are single-cycle pulses.
module cmd_queue_scan
    import cqs_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_valid,
    input  logic [MSG_W-1:0] push_data,
    output logic             push_ready,
    output logic             fill_req,
    output logic             cmd_valid,
    output logic [CMD_W-1:0] cmd_out,
    input  logic             cmd_ready,
    input  logic             mode_in,
    input  logic             arm,
    input  logic             disarm,
    input  logic             sw_trig,
    input  logic             hw_trig,
    input  logic             clr_flags,
    output logic [1:0]       state_o,
    output logic             mode_o,
    output logic             ovf_flag,
    output logic             udf_flag,
    output logic             eoq_flag
);
    logic [MSG_W-1:0]        head;
    logic                    full, empty, xfer_en;
    logic                    push_fire, pop_fire, head_eoq;
    logic [NFLAGS-1:0]       fl_set, fl_q;
    logic [EOQ_POS-CMD_W-1:0] unused_hdr;
    scan_state_e             state;

    // Handshake and event decode.
    always_comb begin
        push_ready = !full;
        fill_req   = !full;
        push_fire  = push_valid && !full;
        cmd_valid  = xfer_en && !empty;
        pop_fire   = cmd_valid && cmd_ready;
        head_eoq   = head[EOQ_POS];
        cmd_out    = head[CMD_W-1:0];
        unused_hdr = head[EOQ_POS-1:CMD_W];
        fl_set[FL_OVF] = push_valid && full;
        fl_set[FL_UDF] = xfer_en && empty;
        fl_set[FL_EOQ] = pop_fire && head_eoq;
    end

    cqs_fifo #(.W(MSG_W), .DEPTH(DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (push_fire),
        .wr_data (push_data),
        .rd_en   (pop_fire),
        .rd_data (head),
        .full    (full),
        .empty   (empty)
    );

    cqs_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm      (arm),
        .disarm   (disarm),
        .trig     (sw_trig || hw_trig),
        .mode_in  (mode_in),
        .pop_fire (pop_fire),
        .pop_eoq  (head_eoq),
        .state    (state),
        .mode_q   (mode_o),
        .xfer_en  (xfer_en)
    );

    cqs_flags #(.N(NFLAGS)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (fl_set),
        .clr   (clr_flags),
        .flag  (fl_q)
    );

    // Status outputs.
    always_comb begin
        state_o  = state;
        ovf_flag = fl_q[FL_OVF];
        udf_flag = fl_q[FL_UDF];
        eoq_flag = fl_q[FL_EOQ];
    end
endmodule

// File: rtl/cqs_chk.sv
// Checker for cmd_queue_scan. It watches the ports and the head EOQ bit.
module cqs_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        push_valid,
    input logic        push_ready,
    input logic        cmd_valid,
    input logic [15:0] cmd_out,
    input logic        cmd_ready,
    input logic        arm,
    input logic        disarm,
    input logic [1:0]  state_o,
    input logic        mode_o,
    input logic        ovf_flag,
    input logic        udf_flag,
    input logic        eoq_flag,
    input logic        head_eoq
);
    // R3
    drop_sets_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && !push_ready) |=> ovf_flag);

    // R4
    valid_only_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (state_o == 2'd2));

    // R5
    single_eoq_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && head_eoq && !mode_o && !disarm)
        |=> (state_o == 2'd3) && eoq_flag);

    // R7
    cont_eoq_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && head_eoq && mode_o && !disarm)
        |=> (state_o == 2'd1));

    // R6
    wait_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd3 && !arm && !disarm) |=> (state_o == 2'd3));

    // R8
    mode_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o != 2'd0) |=> $stable(mode_o));

    // R8
    disarm_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        disarm |=> (state_o == 2'd0));

    // R9
    starve_udf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd2 && !cmd_valid) |=> udf_flag);

    // R11
    hold_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready && !disarm) |=> cmd_valid && $stable(cmd_out));
endmodule

bind cmd_queue_scan cqs_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_valid (push_valid),
    .push_ready (push_ready),
    .cmd_valid  (cmd_valid),
    .cmd_out    (cmd_out),
    .cmd_ready  (cmd_ready),
    .arm        (arm),
    .disarm     (disarm),
    .state_o    (state_o),
    .mode_o     (mode_o),
    .ovf_flag   (ovf_flag),
    .udf_flag   (udf_flag),
    .eoq_flag   (eoq_flag),
    .head_eoq   (head_eoq)
);

// File: tb/sim_cmd_queue_scan.sv
module sim_cmd_queue_scan;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push_valid = 1'b0;
    logic [31:0] push_data = '0;
    logic        push_ready, fill_req, cmd_valid;
    logic [15:0] cmd_out;
    logic        cmd_ready = 1'b0;
    logic        mode_in = 1'b0, arm = 1'b0, disarm = 1'b0;
    logic        sw_trig = 1'b0, hw_trig = 1'b0, clr_flags = 1'b0;
    logic [1:0]  state_o;
    logic        mode_o, ovf_flag, udf_flag, eoq_flag;

    int n_chk = 0;
    int n_bad = 0;
    int held  = 0;
    logic [15:0] exp_q[$];
    logic [15:0] snap;

    always #5 clk = ~clk;

    cmd_queue_scan u0 (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Driver: offer one message; R3 acceptance predicted from the bench's count.
    task automatic push_msg(input logic eoq, input logic [15:0] cmd);
        logic acc;
        acc = (held < 4);
        check("R3 push_ready", push_ready, acc);
        check("R3 fill_req", fill_req, acc);
        push_valid = 1'b1;
        push_data  = {eoq, 15'h1234, cmd};
        if (acc) begin
            exp_q.push_back(cmd);
            held++;
        end
        tick(1);
        push_valid = 1'b0;
    endtask

    task automatic pulse(ref logic sig);
        sig = 1'b1;
        tick(1);
        sig = 1'b0;
    endtask

    // Monitor: compare each command taken by the back end (R2).
    always @(negedge clk) begin
        if (rst_n && cmd_valid && cmd_ready) begin
            n_chk++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL R2 actual=%0h expected=none", cmd_out);
            end else begin
                logic [15:0] e;
                e = exp_q.pop_front();
                held--;
                if (cmd_out !== e) begin
                    n_bad++;
                    $display("FAIL R2 actual=%0h expected=%0h", cmd_out, e);
                end
            end
        end
    end

    initial begin : watchdog
        #1000000;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        check("R1 state", state_o, 0);
        check("R1 cmd_valid", cmd_valid, 0);
        check("R1 fill_req", fill_req, 1);
        check("R1 flags", {ovf_flag, udf_flag, eoq_flag}, 0);

        // Single scan: arm, fill, overflow, no release without trigger.
        pulse(arm);
        check("R8 arm from idle", state_o, 1);
        push_msg(0, 16'h0a01);
        push_msg(0, 16'h0a02);
        push_msg(0, 16'h0a03);
        push_msg(1, 16'h0a04);
        push_msg(0, 16'h0bad);
        check("R3 overflow flag", ovf_flag, 1);
        check("R4 no trigger no valid", cmd_valid, 0);
        cmd_ready = 1'b1;
        pulse(sw_trig);
        tick(6);
        check("R5 wait state", state_o, 3);
        check("R5 eoq flag", eoq_flag, 1);
        check("R9 no starvation", udf_flag, 0);
        check("R2 drained", exp_q.size(), 0);

        // R6 triggers ignored while waiting for rearm.
        push_msg(0, 16'h0c01);
        push_msg(0, 16'h0c02);
        pulse(sw_trig);
        pulse(hw_trig);
        tick(2);
        check("R6 valid low", cmd_valid, 0);
        check("R6 still waiting", state_o, 3);
        check("R6 held", exp_q.size(), 2);
        pulse(arm);
        check("R6 rearmed", state_o, 1);
        pulse(hw_trig);
        tick(4);
        check("R9 starved", udf_flag, 1);
        check("R4 transferring", state_o, 2);
        check("R2 drained", exp_q.size(), 0);

        // R10 clear with a live set condition.
        pulse(clr_flags);
        check("R10 ovf cleared", ovf_flag, 0);
        check("R10 eoq cleared", eoq_flag, 0);
        check("R10 set wins", udf_flag, 1);
        pulse(disarm);
        check("R8 disarm to idle", state_o, 0);
        pulse(clr_flags);
        check("R10 all clear", {ovf_flag, udf_flag, eoq_flag}, 0);

        // Continuous scan.
        mode_in = 1'b1;
        tick(1);
        check("R8 mode taken in idle", mode_o, 1);
        pulse(arm);
        mode_in = 1'b0;
        push_msg(0, 16'h0d01);
        push_msg(1, 16'h0d02);
        pulse(sw_trig);
        tick(4);
        check("R7 back to armed", state_o, 1);
        check("R8 mode kept", mode_o, 1);
        push_msg(1, 16'h0d03);
        pulse(hw_trig);
        tick(3);
        check("R7 resumed", exp_q.size(), 0);
        check("R7 armed again", state_o, 1);

        // R11 backpressure.
        cmd_ready = 1'b0;
        push_msg(1, 16'h0e01);
        pulse(sw_trig);
        check("R11 valid", cmd_valid, 1);
        snap = cmd_out;
        tick(3);
        check("R11 valid held", cmd_valid, 1);
        check("R11 data held", cmd_out, snap);
        cmd_ready = 1'b1;
        tick(3);
        check("R11 drained", exp_q.size(), 0);
        check("R7 armed after", state_o, 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule